// File: doc/BRIEF.md
# Cache Cluster Dimension Controller

This block keeps, for one core, the number of L2 banks that the core's cache cluster spans, and resizes that number by hill-climbing on average memory access time. A free-running counter divides time into programmable periods. During a period the block adds up the core's L2 accesses, its misses and the latency reported for each access. On the last cycle of a period it forms a figure of merit: the latency sum plus the miss count times a programmable memory latency, divided by the access count. A bit-serial divider produces this quotient. A decision stage then compares it with the figure kept from the last period that had accesses.

The decision works like a hill-climber. The block remembers whether its last move grew or shrank the cluster. If the figure fell, it takes one more step the same way. If the figure rose, it turns round and steps the other way. A tie leaves everything as it is. The size moves one rung at a time along the power-of-two ladder from one bank up to 2^MAX_LOG2 banks. When a step would leave the ladder, the size stays and the remembered direction turns round. The consumer, a bank-mapping stage, receives the size as a one-hot bank count, together with a one-cycle strobe on every change.

Top module: `cluster_dim_ctrl`

## Requirements
- R1: Out of reset the dimension is 2^INIT_LOG2 banks (16 by default), `dim_change` is low, and no previous figure is held.
- R2: `dim_banks` is always one-hot: bit k set means 2^k banks. Every change doubles or halves it.
- R3: A period's last cycle is the cycle in which the internal cycle counter, which counts from 0 after reset, is at least `cfg_period`-1. The counter then restarts at 0. A resize decided for that period appears on `dim_banks` exactly NUM_W+1 rising edges after the edge that ends that cycle, where NUM_W = LAT_W+PERIOD_W+1. `cfg_period` must be at least NUM_W+3.
- R4: The period figure is floor((sum of `acc_lat` over valid accesses + misses × `cfg_mem_lat`) / valid accesses). The sum covers every cycle of the period, including its last cycle. A miss is a valid access with `acc_hit` low. `cfg_mem_lat` is sampled on the period's last cycle.
- R5: The first period with accesses after reset only stores its figure and leaves the dimension and the direction unchanged.
- R6: If the figure is greater than the stored one, the direction is reversed and one step is taken in the new direction.
- R7: If the figure is smaller than the stored one, one step is taken in the current direction.
- R8: If the figure equals the stored one, the dimension and the direction are kept.
- R9: A step above 2^MAX_LOG2 or below 1 bank leaves the dimension unchanged and reverses the stored direction.
- R10: A period with no valid access changes nothing: not the dimension, not the direction, not the stored figure.
- R11: `dim_change` is high for exactly the one cycle in which `dim_banks` has just taken a new value, and low at all other times.
- R12: The direction after reset is shrink, so the first downhill step halves the cluster.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PERIOD_W | Period length in cycles |
| cfg_mem_lat | input | LAT_W | Latency charged per L2 miss |
| acc_valid | input | 1 | An L2 access completes this cycle |
| acc_hit | input | 1 | That access hit in L2 |
| acc_lat | input | LAT_W | Latency of that access |
| dim_banks | output | MAX_LOG2+1 | One-hot cluster size in banks |
| dim_change | output | 1 | One-cycle pulse when `dim_banks` changes |

## Verification
Each decision lands a fixed NUM_W+1 rising edges after the edge that closes its period: one edge loads the divider, NUM_W edges produce the quotient bits, and one more registers the new dimension and the strobe. The reference model in the bench counts rising edges from reset. It works out each decision when the period closes and holds the result in a pending slot until that exact edge. The bench compares dimension and strobe at every falling edge, so an early or late update shows up as a miscompare. The scripted period checks sample on a period's last cycle, long after the previous decision has landed, and compare against dimensions worked out by hand.

// File: rtl/cdc_pkg.sv
package cdc_pkg;
    typedef enum logic {
        DIR_SHRINK = 1'b0,
        DIR_GROW   = 1'b1
    } dir_e;

    function automatic dir_e dir_flip(dir_e d);
        return (d == DIR_GROW) ? DIR_SHRINK : DIR_GROW;
    endfunction
endpackage

// File: rtl/cdc_period_timer.sv
module cdc_period_timer #(
    parameter int PERIOD_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    output logic                point_o
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } tmr_t;

    tmr_t s_q, s_d;
    logic last;

    always_comb begin
        last    = ({1'b0, s_q.cnt} >= ({1'b0, cfg_period} - 1'b1));
        s_d     = s_q;
        s_d.cnt = last ? '0 : s_q.cnt + 1'b1;
        point_o = last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cdc_accum.sv
module cdc_accum #(
    parameter int CNT_W = 20,
    parameter int LAT_W = 10,
    parameter int NUM_W = CNT_W + LAT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             point_i,
    input  logic             acc_valid,
    input  logic             acc_hit,
    input  logic [LAT_W-1:0] acc_lat,
    input  logic [LAT_W-1:0] cfg_mem_lat,
    output logic [NUM_W-1:0] num_o,
    output logic [CNT_W-1:0] den_o,
    output logic             empty_o
);
    localparam int SUM_W = CNT_W + LAT_W;

    typedef struct packed {
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] miss;
        logic [SUM_W-1:0] lat;
    } acc_t;

    acc_t s_q, s_d, nx;
    logic [SUM_W-1:0] miss_cost;

    always_comb begin
        nx      = s_q;
        if (acc_valid) begin
            nx.acc = s_q.acc + 1'b1;
            nx.lat = s_q.lat + SUM_W'(acc_lat);
            if (!acc_hit) nx.miss = s_q.miss + 1'b1;
        end
        miss_cost = SUM_W'(nx.miss) * SUM_W'(cfg_mem_lat);
        num_o     = NUM_W'(nx.lat) + NUM_W'(miss_cost);
        den_o     = nx.acc;
        empty_o   = (nx.acc == '0);
        s_d       = point_i ? '0 : nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cdc_divider.sv
module cdc_divider #(
    parameter int NUM_W = 31,
    parameter int DEN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    input  logic             empty_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             empty_o,
    output logic             done_o,
    output logic             busy_o
);
    localparam int LEFT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              empty;
        logic [LEFT_W-1:0] left;
        logic [NUM_W:0]    rem;
        logic [NUM_W-1:0]  quo;
        logic [DEN_W-1:0]  den;
    } div_t;

    div_t s_q, s_d;
    logic [NUM_W:0] trial;
    logic [NUM_W:0] den_x;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        den_x    = {{(NUM_W + 1 - DEN_W){1'b0}}, s_q.den};
        trial    = {s_q.rem[NUM_W-1:0], s_q.quo[NUM_W-1]};
        if (start_i) begin
            s_d.busy  = 1'b1;
            s_d.left  = LEFT_W'(NUM_W);
            s_d.rem   = '0;
            s_d.quo   = num_i;
            s_d.den   = den_i;
            s_d.empty = empty_i;
        end else if (s_q.busy) begin
            s_d.quo = {s_q.quo[NUM_W-2:0], 1'b0};
            if (trial >= den_x) begin
                s_d.rem    = trial - den_x;
                s_d.quo[0] = 1'b1;
            end else begin
                s_d.rem = trial;
            end
            s_d.left = s_q.left - 1'b1;
            if (s_q.left == LEFT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
        quo_o   = s_q.quo;
        empty_o = s_q.empty;
        done_o  = s_q.done;
        busy_o  = s_q.busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cdc_decide.sv
module cdc_decide
    import cdc_pkg::*;
#(
    parameter int   NUM_W     = 31,
    parameter int   MAX_LOG2  = 4,
    parameter int   INIT_LOG2 = 4,
    parameter dir_e INIT_DIR  = DIR_SHRINK,
    localparam int  LOG_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    input  logic             empty_i,
    input  logic [NUM_W-1:0] amat_i,
    output logic [LOG_W-1:0] log_o,
    output logic             strobe_o
);
    localparam logic [LOG_W-1:0] TOP_L  = LOG_W'(MAX_LOG2);
    localparam logic [LOG_W-1:0] INIT_L = LOG_W'(INIT_LOG2);

    typedef struct packed {
        logic [LOG_W-1:0] lg;
        dir_e             dir;
        logic [NUM_W-1:0] prev;
        logic             have;
        logic             strobe;
    } dec_t;

    dec_t s_q, s_d;
    dir_e want;
    logic move;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        want       = s_q.dir;
        move       = 1'b0;
        if (done_i && !empty_i) begin
            s_d.prev = amat_i;
            s_d.have = 1'b1;
            if (s_q.have) begin
                if (amat_i > s_q.prev) begin
                    want = dir_flip(s_q.dir);
                    move = 1'b1;
                end else if (amat_i < s_q.prev) begin
                    want = s_q.dir;
                    move = 1'b1;
                end
            end
        end
        if (move) begin
            if (want == DIR_GROW) begin
                if (s_q.lg < TOP_L) begin
                    s_d.lg     = s_q.lg + 1'b1;
                    s_d.dir    = DIR_GROW;
                    s_d.strobe = 1'b1;
                end else begin
                    s_d.dir = DIR_SHRINK;
                end
            end else begin
                if (s_q.lg != '0) begin
                    s_d.lg     = s_q.lg - 1'b1;
                    s_d.dir    = DIR_SHRINK;
                    s_d.strobe = 1'b1;
                end else begin
                    s_d.dir = DIR_GROW;
                end
            end
        end
        log_o    = s_q.lg;
        strobe_o = s_q.strobe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.lg     <= INIT_L;
            s_q.dir    <= INIT_DIR;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/cluster_dim_ctrl.sv
module cluster_dim_ctrl
    import cdc_pkg::*;
#(
    parameter int PERIOD_W  = 20,
    parameter int LAT_W     = 10,
    parameter int MAX_LOG2  = 4,
    parameter int INIT_LOG2 = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [LAT_W-1:0]    cfg_mem_lat,
    input  logic                acc_valid,
    input  logic                acc_hit,
    input  logic [LAT_W-1:0]    acc_lat,
    output logic [MAX_LOG2:0]   dim_banks,
    output logic                dim_change
);
    localparam int NUM_W = LAT_W + PERIOD_W + 1;
    localparam int LOG_W = $clog2(MAX_LOG2 + 1);

    logic             point;
    logic [NUM_W-1:0] acc_num;
    logic [PERIOD_W-1:0] acc_den;
    logic             acc_empty;
    logic [NUM_W-1:0] div_quo;
    logic             div_empty;
    logic             div_done;
    logic             div_busy;
    logic [LOG_W-1:0] cur_log;

    cdc_period_timer #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .point_o(point)
    );

    cdc_accum #(.CNT_W(PERIOD_W), .LAT_W(LAT_W), .NUM_W(NUM_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .point_i(point),
        .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_lat(acc_lat),
        .cfg_mem_lat(cfg_mem_lat),
        .num_o(acc_num), .den_o(acc_den), .empty_o(acc_empty)
    );

    cdc_divider #(.NUM_W(NUM_W), .DEN_W(PERIOD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start_i(point),
        .num_i(acc_num), .den_i(acc_den), .empty_i(acc_empty),
        .quo_o(div_quo), .empty_o(div_empty), .done_o(div_done), .busy_o(div_busy)
    );

    cdc_decide #(
        .NUM_W(NUM_W), .MAX_LOG2(MAX_LOG2), .INIT_LOG2(INIT_LOG2), .INIT_DIR(DIR_SHRINK)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .done_i(div_done), .empty_i(div_empty),
        .amat_i(div_quo), .log_o(cur_log), .strobe_o(dim_change)
    );

    for (genvar g = 0; g <= MAX_LOG2; g++) begin : g_onehot
        assign dim_banks[g] = (cur_log == LOG_W'(g));
    end
endmodule

// File: rtl/cdc_checker.sv
module cdc_checker #(
    parameter int MAX_LOG2 = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MAX_LOG2:0] dim_banks,
    input logic              dim_change,
    input logic              div_done,
    input logic              div_empty,
    input logic              div_busy,
    input logic              point
);
    a_r2_legal_dim: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(dim_banks));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dim_banks != $past(dim_banks)) |->
        ((dim_banks == ($past(dim_banks) << 1)) || (dim_banks == ($past(dim_banks) >> 1))));

    a_r11_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        dim_change == (dim_banks != $past(dim_banks)));

    a_r3_change_after_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        dim_change |-> $past(div_done));

    a_r10_idle_period_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (div_done && div_empty) |=> !dim_change);

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        point |-> !div_busy);
endmodule

bind cluster_dim_ctrl cdc_checker #(.MAX_LOG2(MAX_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .dim_banks(dim_banks), .dim_change(dim_change),
    .div_done(div_done), .div_empty(div_empty), .div_busy(div_busy), .point(point)
);

// File: tb/cluster_dim_ctrl_bench.sv
`timescale 1ns/1ps
module cluster_dim_ctrl_bench;
    localparam int PERIOD_W = 20;
    localparam int LAT_W    = 10;
    localparam int MAXL     = 4;
    localparam int NUM_W    = LAT_W + PERIOD_W + 1;
    localparam int DEC_LAT  = NUM_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PERIOD_W-1:0] cfg_period = 20'd80;
    logic [LAT_W-1:0] cfg_mem_lat = '0;
    logic acc_valid = 1'b0;
    logic acc_hit = 1'b0;
    logic [LAT_W-1:0] acc_lat = '0;
    logic [MAXL:0] dim_banks;
    logic dim_change;

    always #5 clk = ~clk;

    cluster_dim_ctrl u_cluster_dim_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_mem_lat(cfg_mem_lat),
        .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_lat(acc_lat),
        .dim_banks(dim_banks), .dim_change(dim_change)
    );

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // behavioural reference model
    longint edge_n, pc, m_acc, m_miss, m_lat, prev_amat, due;
    int  m_log, vis_log, pend_log;
    bit  m_grow, have_prev, vis_strobe, pend;

    always @(posedge clk) begin
        if (!rst_n) begin
            edge_n = 0; pc = 0; m_acc = 0; m_miss = 0; m_lat = 0;
            m_log = 4; vis_log = 4; m_grow = 0; have_prev = 0;
            vis_strobe = 0; pend = 0; prev_amat = 0; due = 0; pend_log = 4;
        end else begin
            edge_n++;
            vis_strobe = 0;
            if (pend && edge_n == due) begin
                pend = 0;
                vis_strobe = (pend_log != vis_log);
                vis_log = pend_log;
            end
            if (acc_valid) begin
                m_acc++;
                m_lat += acc_lat;
                if (!acc_hit) m_miss++;
            end
            if (pc >= longint'(cfg_period) - 1) begin
                if (m_acc != 0) begin
                    longint amat;
                    amat = (m_lat + m_miss * longint'(cfg_mem_lat)) / m_acc;
                    if (have_prev && amat != prev_amat) begin
                        bit want;
                        want = (amat > prev_amat) ? !m_grow : m_grow;
                        if (want && m_log < MAXL) begin m_log++; m_grow = 1; end
                        else if (!want && m_log > 0) begin m_log--; m_grow = 0; end
                        else m_grow = !want;
                    end
                    have_prev = 1;
                    prev_amat = amat;
                    pend = 1; due = edge_n + DEC_LAT; pend_log = m_log;
                end
                pc = 0; m_acc = 0; m_miss = 0; m_lat = 0;
            end else begin
                pc++;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            vectors++;
            if (dim_banks != (5'd1 << vis_log)) begin
                errors++;
                $display("FAIL R3 dim_banks actual %b expected %b at edge %0d",
                         dim_banks, 5'd1 << vis_log, edge_n);
            end
            vectors++;
            if (dim_change != vis_strobe) begin
                errors++;
                $display("FAIL R11 dim_change actual %0b expected %0b at edge %0d",
                         dim_change, vis_strobe, edge_n);
            end
        end
    end

    task automatic check_dim(input int exp_banks, input string tag);
        vectors++;
        if (dim_banks != exp_banks[MAXL:0]) begin
            errors++;
            $display("FAIL %s dim_banks actual %0d expected %0d", tag, dim_banks, exp_banks);
        end
    endtask

    // one period of all-hit accesses of fixed latency; n=0 gives an idle period
    // checks the previous decision on the period's last cycle
    task automatic run_fixed(input int n, input int lat, input int exp_banks, input string tag);
        for (int i = 0; i < int'(cfg_period); i++) begin
            acc_valid = (i < n);
            acc_hit   = 1'b1;
            acc_lat   = LAT_W'(lat);
            if (i == int'(cfg_period) - 1 && exp_banks > 0) check_dim(exp_banks, tag);
            @(negedge clk);
        end
        acc_valid = 1'b0;
    endtask

    task automatic run_mixed();
        // 8 hits and 2 misses at latency 10, miss cost 100: figure 30
        cfg_mem_lat = 10'd100;
        for (int i = 0; i < int'(cfg_period); i++) begin
            acc_valid = (i < 10);
            acc_hit   = (i >= 2);
            acc_lat   = 10'd10;
            @(negedge clk);
        end
        acc_valid = 1'b0;
    endtask

    task automatic run_random();
        cfg_mem_lat = LAT_W'($urandom_range(0, 1023));
        for (int i = 0; i < int'(cfg_period); i++) begin
            acc_valid = ($urandom_range(0, 3) != 0);
            acc_hit   = ($urandom_range(0, 4) != 0);
            acc_lat   = LAT_W'($urandom_range(0, 1023));
            @(negedge clk);
        end
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        vectors++;
        if (dim_banks != 5'd16 || dim_change != 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual banks %0d strobe %0b expected 16 0", dim_banks, dim_change);
        end
        rst_n = 1'b1;
        run_mixed();                               // first figure 30
        run_fixed(10, 15, 16, "R5");               // first period only stored
        run_fixed(10, 10, 8,  "R4 R12");           // 15 < 30, shrink first
        run_fixed(10, 12, 4,  "R7");               // 10 < 15, keep shrinking
        run_fixed(10, 12, 8,  "R6");               // 12 > 10, turn and grow
        run_fixed(0,  0,  8,  "R8");               // 12 == 12, hold
        run_fixed(10, 9,  8,  "R10");              // idle period held
        run_fixed(10, 5,  16, "R10 R7");           // 9 < stored 12, grow
        run_fixed(10, 4,  16, "R9");               // grow at top saturates
        run_fixed(10, 3,  8,  "R9");               // direction flipped to shrink
        run_fixed(10, 2,  4,  "R7");
        run_fixed(10, 1,  2,  "R7");
        run_fixed(10, 0,  1,  "R7");
        run_fixed(10, 0,  1,  "R9");               // shrink at bottom saturates
        run_fixed(10, 0,  1,  "R8");               // tie at zero
        for (int p = 0; p < 20; p++) run_random();
        cfg_period = 20'd50;
        for (int p = 0; p < 12; p++) run_random();
        run_fixed(0, 0, 0, "");
        repeat (DEC_LAT + 4) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule